// File: doc/BRIEF.md
# Dual-Port Byte Memory with Collision Arbitration

This block is a 2048-entry, byte-wide memory with two independent ports, called left and right. Each port has its own address, write data, read data, active-low select, read/write control and active-low output enable. Either port can read or write any location in any cycle. Reads are registered, so data and a valid flag appear one clock after the request. Everything runs on one clock.

A mode input picks how busy works. In master mode the block watches for both ports selecting the same location. It picks one port to proceed, drops the active-low busy output of the other port in that same cycle, and blocks that port's write. The port whose select and address were already steady on the previous edge wins. When both arrive on the same edge, left wins. The arbitration state machine has three states: `ARB_FREE` (no contention), `ARB_LEFT_WINS` (right busy) and `ARB_RIGHT_WINS` (left busy). The transitions are:
- `ARB_FREE` to `ARB_LEFT_WINS` on a new match, unless only the right port was steady.
- `ARB_FREE` to `ARB_RIGHT_WINS` on a new match where only the right port was steady.
- Either winner state back to `ARB_FREE` once the match ends.
- Otherwise the state holds.

In slave mode no arbitration takes place. Each port's busy input is then a write-inhibit line driven by an external master, so several copies can be placed side by side to widen the word.

Top module: `dpram_arb`

## Requirements
- R1: While reset is held, both read-valid flags are 0, both read-data buses are 0 and both busy outputs are 1.
- R2: A port with select low and read/write low writes its data to its address at the clock edge. A port with select low, read/write high and output enable low shows the stored byte on read data, with read-valid 1, after the next edge. A read one cycle after a write to the same address returns the new byte.
- R3: A port whose select is high writes nothing and shows read-valid 0 after the next edge.
- R4: A read with output enable high gives read-valid 0 and read data 0 after the next edge.
- R5: In master mode a busy output goes low only while both selects are low and both addresses are equal. The read/write controls have no part in this.
- R6: When both ports start matching on the same edge, the right busy goes low and the left busy stays high.
- R7: When one port held the same selected address on the previous edge and the other port newly matches it, the newly arriving port gets busy.
- R8: The winner is kept for as long as the match lasts, and the two busy outputs are never low together.
- R9: A write from a port whose busy is low does not change the memory.
- R10: Busy returns high in the same cycle in which the addresses stop matching or either select goes high.
- R11: In slave mode (mode input 0) both busy outputs stay 1. A low busy input blocks that port's writes. When both ports write the same address in one cycle, the right port's byte is stored.
- R12: Two writes to different addresses in one cycle, with neither port busy, both commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of read outputs and arbitration state |
| master_mode | input | 1 | 1 = arbitrate and drive busy; 0 = busy inputs act as write inhibit |
| l_cs_n | input | 1 | Left select, active low |
| l_rw | input | 1 | Left direction, 1 = read, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| l_rdata | output | DATA_W | Left read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left busy from arbitration, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_rw | input | 1 | Right direction, 1 = read, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| r_rdata | output | DATA_W | Right read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right busy from arbitration, active low |

## Verification
The bench builds the block with a 4-bit address and 8-bit data, which gives 16 locations. With 16 locations, every pair of left and right addresses can be driven into a simultaneous collision (256 pairs), and the whole array can be read back after each phase against a bench-side copy. The same small array also makes the arrival-order cases, the release cases and the slave-mode inhibit quick to set up on chosen addresses.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int NUM_PORTS  = 2;
    localparam int PORT_LEFT  = 0;
    localparam int PORT_RIGHT = 1;

    typedef enum logic [1:0] {
        ARB_FREE       = 2'd0,
        ARB_LEFT_WINS  = 2'd1,
        ARB_RIGHT_WINS = 2'd2
    } arb_state_e;

endpackage

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl (
    input  logic cs_n,
    input  logic rw,
    input  logic oe_n,
    input  logic master_mode,
    input  logic arb_busy,
    input  logic ext_busy_n,
    output logic wr_en,
    output logic rd_en,
    output logic busy_n
);

    logic inhibit;

    always_comb begin
        // master: arbitration decides; slave: external line decides
        inhibit = master_mode ? arb_busy : ~ext_busy_n;
        wr_en   = ~cs_n & ~rw & ~inhibit;
        rd_en   = ~cs_n & rw & ~oe_n;
        busy_n  = ~(master_mode & arb_busy);
    end

endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            master_mode,
    input  logic [NUM_PORTS-1:0]            sel,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
    output logic [NUM_PORTS-1:0]            busy
);

    arb_state_e                      state_q;
    arb_state_e                      state_d;
    logic [NUM_PORTS-1:0]            sel_q;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_q;
    logic [NUM_PORTS-1:0]            steady;
    logic                            match;

    always_comb begin
        match = master_mode & sel[PORT_LEFT] & sel[PORT_RIGHT]
              & (addr[PORT_LEFT] == addr[PORT_RIGHT]);
        for (int p = 0; p < NUM_PORTS; p++) begin
            steady[p] = sel_q[p] & (addr_q[p] == addr[p]);
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: begin
                if (!match)
                    state_d = ARB_FREE;
                else if (steady[PORT_RIGHT] && !steady[PORT_LEFT])
                    state_d = ARB_RIGHT_WINS;
                else
                    state_d = ARB_LEFT_WINS;
            end
            ARB_LEFT_WINS:  state_d = match ? ARB_LEFT_WINS  : ARB_FREE;
            ARB_RIGHT_WINS: state_d = match ? ARB_RIGHT_WINS : ARB_FREE;
            default:        state_d = ARB_FREE;
        endcase
    end

    // state register plus arrival history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            sel_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel;
            addr_q  <= addr;
        end
    end

    // outputs: decision applies in the current cycle
    always_comb begin
        busy = '0;
        unique case (state_d)
            ARB_LEFT_WINS:  busy[PORT_RIGHT] = 1'b1;
            ARB_RIGHT_WINS: busy[PORT_LEFT]  = 1'b1;
            ARB_FREE:       busy = '0;
            default:        busy = '0;
        endcase
    end

endmodule

// File: rtl/dpram_core.sv
module dpram_core
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             wr_en,
    input  logic [NUM_PORTS-1:0]             rd_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] rdata,
    output logic [NUM_PORTS-1:0]             rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // right port is applied last, so it lands on a same-address tie
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en[p]) mem[addr[p]] <= wdata[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                rdata[p]  <= rd_en[p] ? mem[addr[p]] : '0;
                rvalid[p] <= rd_en[p];
            end
        end
    end

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_cs_n,
    input  logic              l_rw,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_in_n,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_busy_n,
    input  logic              r_cs_n,
    input  logic              r_rw,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_in_n,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_busy_n
);

    logic [NUM_PORTS-1:0]             cs_n_v, rw_v, oe_n_v, ext_busy_n_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_v, rdata_v;
    logic [NUM_PORTS-1:0]             sel_v, arb_busy_v, wr_en_v, rd_en_v;
    logic [NUM_PORTS-1:0]             busy_n_v, rvalid_v;

    always_comb begin
        cs_n_v[PORT_LEFT]        = l_cs_n;
        cs_n_v[PORT_RIGHT]       = r_cs_n;
        rw_v[PORT_LEFT]          = l_rw;
        rw_v[PORT_RIGHT]         = r_rw;
        oe_n_v[PORT_LEFT]        = l_oe_n;
        oe_n_v[PORT_RIGHT]       = r_oe_n;
        ext_busy_n_v[PORT_LEFT]  = l_busy_in_n;
        ext_busy_n_v[PORT_RIGHT] = r_busy_in_n;
        addr_v[PORT_LEFT]        = l_addr;
        addr_v[PORT_RIGHT]       = r_addr;
        wdata_v[PORT_LEFT]       = l_wdata;
        wdata_v[PORT_RIGHT]      = r_wdata;
        sel_v                    = ~cs_n_v;
    end

    dpram_arbiter #(.ADDR_W(ADDR_W)) arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .sel         (sel_v),
        .addr        (addr_v),
        .busy        (arb_busy_v)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpram_port_ctl ctl_i (
            .cs_n        (cs_n_v[p]),
            .rw          (rw_v[p]),
            .oe_n        (oe_n_v[p]),
            .master_mode (master_mode),
            .arb_busy    (arb_busy_v[p]),
            .ext_busy_n  (ext_busy_n_v[p]),
            .wr_en       (wr_en_v[p]),
            .rd_en       (rd_en_v[p]),
            .busy_n      (busy_n_v[p])
        );
    end

    dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en_v),
        .rd_en  (rd_en_v),
        .addr   (addr_v),
        .wdata  (wdata_v),
        .rdata  (rdata_v),
        .rvalid (rvalid_v)
    );

    always_comb begin
        l_rdata  = rdata_v[PORT_LEFT];
        r_rdata  = rdata_v[PORT_RIGHT];
        l_rvalid = rvalid_v[PORT_LEFT];
        r_rvalid = rvalid_v[PORT_RIGHT];
        l_busy_n = busy_n_v[PORT_LEFT];
        r_busy_n = busy_n_v[PORT_RIGHT];
    end

endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_cs_n,
    input logic              l_rw,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_rvalid,
    input logic              l_busy_n,
    input logic              r_cs_n,
    input logic              r_rw,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_rvalid,
    input logic              r_busy_n
);

    logic same_loc;
    assign same_loc = master_mode && !l_cs_n && !r_cs_n && (l_addr == r_addr);

    assert_busy_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    assert_busy_needs_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n || !r_busy_n) |-> same_loc);

    assert_slave_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_n && r_busy_n));

    assert_left_win_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && same_loc) |=> (!same_loc || !r_busy_n));

    assert_right_win_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && same_loc) |=> (!same_loc || !l_busy_n));

    assert_left_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cs_n || !l_rw || l_oe_n) |=> !l_rvalid);

    assert_right_no_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_cs_n || !r_rw || r_oe_n) |=> !r_rvalid);

    assert_left_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && l_rw && !l_oe_n) |=> l_rvalid);

    assert_right_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_cs_n && r_rw && !r_oe_n) |=> r_rvalid);

endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_cs_n      (l_cs_n),
    .l_rw        (l_rw),
    .l_oe_n      (l_oe_n),
    .l_addr      (l_addr),
    .l_rvalid    (l_rvalid),
    .l_busy_n    (l_busy_n),
    .r_cs_n      (r_cs_n),
    .r_rw        (r_rw),
    .r_oe_n      (r_oe_n),
    .r_addr      (r_addr),
    .r_rvalid    (r_rvalid),
    .r_busy_n    (r_busy_n)
);

// File: tb/dpram_arb_tb_top.sv
module dpram_arb_tb_top;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, master_mode;
    logic          l_cs_n, l_rw, l_oe_n, l_busy_in_n, l_rvalid, l_busy_n;
    logic          r_cs_n, r_rw, r_oe_n, r_busy_in_n, r_rvalid, r_busy_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_cs_n(l_cs_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_busy_in_n(l_busy_in_n), .l_rdata(l_rdata),
        .l_rvalid(l_rvalid), .l_busy_n(l_busy_n),
        .r_cs_n(r_cs_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_busy_in_n(r_busy_in_n), .r_rdata(r_rdata),
        .r_rvalid(r_rvalid), .r_busy_n(r_busy_n)
    );

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        l_cs_n = 1; l_rw = 1; l_oe_n = 0; l_addr = '0; l_wdata = '0; l_busy_in_n = 1;
        r_cs_n = 1; r_rw = 1; r_oe_n = 0; r_addr = '0; r_wdata = '0; r_busy_in_n = 1;
    endtask

    task automatic rd_right(input int a, input string tag);
        r_cs_n = 0; r_rw = 1; r_oe_n = 0; r_addr = AW'(a);
        step();
        check(tag, 32'(r_rvalid), 32'd1);
        check(tag, 32'(r_rdata), 32'(model[a]));
        r_cs_n = 1;
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < DEPTH; a++) rd_right(a, tag);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 0; master_mode = 1;
        idle();
        repeat (3) step();
        // R1 reset state
        check("R1 l_rvalid", 32'(l_rvalid), 0);
        check("R1 r_rvalid", 32'(r_rvalid), 0);
        check("R1 l_rdata", 32'(l_rdata), 0);
        check("R1 r_rdata", 32'(r_rdata), 0);
        check("R1 l_busy_n", 32'(l_busy_n), 1);
        check("R1 r_busy_n", 32'(r_busy_n), 1);
        rst_n = 1;
        step();

        // R12: both ports write different addresses in one cycle
        for (int a = 0; a < DEPTH/2; a++) begin
            l_cs_n = 0; l_rw = 0; l_addr = AW'(a);           l_wdata = DW'(a*7 + 3);
            r_cs_n = 0; r_rw = 0; r_addr = AW'(a + DEPTH/2); r_wdata = DW'(8'hA0 ^ a);
            model[a] = DW'(a*7 + 3);
            model[a + DEPTH/2] = DW'(8'hA0 ^ a);
            step();
        end
        idle();
        sweep("R12 fill readback");

        // R2 read right after write
        l_cs_n = 0; l_rw = 0; l_addr = 5; l_wdata = 8'h5A;
        model[5] = 8'h5A;
        step();
        l_cs_n = 1;
        rd_right(5, "R2 read-after-write");

        // R3 deselected write is ignored
        l_cs_n = 1; l_rw = 0; l_addr = 3; l_wdata = 8'hFF;
        step();
        check("R3 l_rvalid", 32'(l_rvalid), 0);
        idle();
        rd_right(3, "R3 location unchanged");

        // R4 output enable high
        l_cs_n = 0; l_rw = 1; l_oe_n = 1; l_addr = 3;
        step();
        check("R4 l_rvalid", 32'(l_rvalid), 0);
        check("R4 l_rdata", 32'(l_rdata), 0);
        l_oe_n = 0;
        step();
        check("R2 l_rvalid", 32'(l_rvalid), 1);
        check("R2 l_rdata", 32'(l_rdata), 32'(model[3]));
        idle();
        step();

        // R5 R6 R9: every address pair starting together
        for (int la = 0; la < DEPTH; la++) begin
            for (int ra = 0; ra < DEPTH; ra++) begin
                logic [DW-1:0] ld, rd;
                ld = DW'((la*16 + ra) ^ 8'h3C);
                rd = ~ld;
                l_cs_n = 0; l_rw = 0; l_addr = AW'(la); l_wdata = ld;
                r_cs_n = 0; r_rw = ra[0]; r_addr = AW'(ra); r_wdata = rd;
                #1;
                check("R6 l_busy_n", 32'(l_busy_n), 1);
                check("R5 r_busy_n", 32'(r_busy_n), (la == ra) ? 0 : 1);
                model[la] = ld;
                if (la != ra && !ra[0]) model[ra] = rd;  // R9: right suppressed on match
                step();
                idle();
                step();
            end
        end
        sweep("R9 collision readback");

        // R7: right steady first, left arrives late
        r_cs_n = 0; r_rw = 1; r_addr = 6;
        step();
        l_cs_n = 0; l_rw = 0; l_addr = 6; l_wdata = 8'h77;
        #1;
        check("R7 l_busy_n", 32'(l_busy_n), 0);
        check("R7 r_busy_n", 32'(r_busy_n), 1);
        step();
        check("R7 r_rdata", 32'(r_rdata), 32'(model[6]));
        check("R8 l_busy_n held", 32'(l_busy_n), 0);
        check("R8 r_busy_n held", 32'(r_busy_n), 1);
        l_rw = 1; r_addr = 7;
        #1;
        check("R10 l_busy_n addr", 32'(l_busy_n), 1);
        check("R10 r_busy_n addr", 32'(r_busy_n), 1);
        step();
        idle();
        rd_right(6, "R9 late writer blocked");
        step();

        // R10: release when a select goes high
        l_cs_n = 0; l_rw = 1; l_addr = 9;
        r_cs_n = 0; r_rw = 1; r_addr = 9;
        #1;
        check("R6 r_busy_n", 32'(r_busy_n), 0);
        step();
        l_cs_n = 1;
        #1;
        check("R10 r_busy_n cs", 32'(r_busy_n), 1);
        check("R10 l_busy_n cs", 32'(l_busy_n), 1);
        step();
        idle();
        step();

        // R11 slave mode
        master_mode = 0;
        l_cs_n = 0; l_rw = 0; l_addr = 2; l_wdata = 8'h11;
        r_cs_n = 0; r_rw = 0; r_addr = 2; r_wdata = 8'h22;
        #1;
        check("R11 l_busy_n", 32'(l_busy_n), 1);
        check("R11 r_busy_n", 32'(r_busy_n), 1);
        model[2] = 8'h22;
        step();
        l_busy_in_n = 0; l_addr = 4; l_wdata = 8'h44;
        r_addr = 12; r_wdata = 8'hCC;
        model[12] = 8'hCC;
        step();
        idle();
        rd_right(2, "R11 same address right lands");
        rd_right(4, "R11 inhibited write");
        rd_right(12, "R11 free write");
        step();

        finish_run();
    end

endmodule